// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block gives software control of sixteen general-purpose pins over a simple 16-bit register bus. Every register holds one bit per pin, and bit n belongs to pin n. A direction register selects, pin by pin, whether the block drives the pin. The drive level changes only through two write strobes. One strobe raises the selected bits and the other lowers them, so software never needs a read-modify-write sequence to change one output. Incoming pin values pass through a synchroniser. After it they appear in a read-only input view and feed the interrupt logic.

Each pin can raise an interrupt. A pin in level mode flags while its input sits at a chosen polarity. A pin in edge mode flags on a rising edge, a falling edge, or both, and each edge has its own enable bit. An edge sets a sticky pending bit, which software clears by writing ones. A pending bit reaches the status view only when its mask bit is clear and its enable bit is set. All visible status bits are ORed into one interrupt line.

The bus is single-cycle. A write is taken on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr` and reflects the register state after the most recent edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the mask register (word 10) reads 0xFFFF. The enable register (word 11), direction (word 0), trigger select (word 1), polarity (word 2), rising enable (word 3), falling enable (word 4) and output data (word 8) all read 0x0000, and `irq` is low.
- R2: The direction register at word 0 is read/write, and `pin_oe` equals it; a 1 means the pin is driven.
- R3: A write to word 6 sets the output bits where the write data is 1. A write to word 7 clears the output bits where the write data is 1. Zero bits in either write leave the outputs unchanged. `pin_out` and a read of word 8 both show the current output value, which changes on the edge that takes the write.
- R4: Word 5 is read-only and returns `pin_in` delayed by two clock edges through the synchroniser.
- R5: When its trigger select bit (word 1) is 0, a pin is in edge mode. Its rising enable (word 3) lets a 0-to-1 change of the synchronised input set its pending bit. Its falling enable (word 4) does the same for a 1-to-0 change, and with both enables set either edge sets it. A new value at `pin_in` sets the pending bit on the third clock edge.
- R6: When its trigger select bit is 1, a pin is in level mode. Its pending bit follows whether the synchronised input equals the polarity bit (word 2): 1 means active-high and 0 means active-low. A clear write has no effect while the level stays active.
- R7: Edge-mode pending bits are sticky until cleared by writing ones to word 13. If a clear and a new edge for the same pin are taken on the same edge, the pin stays pending.
- R8: Word 12 reads pending AND NOT mask AND enable. `irq` is the OR of those bits, so a set mask bit or a clear enable bit hides a pin without losing its pending state.
- R9: Reads of word 6, word 7, word 13 and unmapped words (9, 14, 15) return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output drive levels |
| pin_oe | output | 16 | Output enables (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge and a clear write for the same pin taken on the same clock edge. The edge reaches the pending logic only after three register stages, so the stimulus changes the pin on a falling clock edge and idles two falling edges. It then raises the clear strobe, which lands on exactly the edge where the event sets the pending bit. Level-mode immunity to clears is reached by writing a clear while the level is held active. A behavioural reference model steps with the clock and predicts outputs and reads throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // Word indices of the register bus. The bench and software depend on them.
   typedef enum logic [3:0] {
      IDX_DIR  = 4'd0,
      IDX_TRIG = 4'd1,
      IDX_POL  = 4'd2,
      IDX_RISE = 4'd3,
      IDX_FALL = 4'd4,
      IDX_DIN  = 4'd5,
      IDX_SET  = 4'd6,
      IDX_CLR  = 4'd7,
      IDX_DOUT = 4'd8,
      IDX_MASK = 4'd10,
      IDX_EN   = 4'd11,
      IDX_STAT = 4'd12,
      IDX_ACK  = 4'd13
   } reg_idx_e;

   localparam int unsigned IDX_W = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_chk
      $error("gpio_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] lvl_mode,
   input  logic [W-1:0] lvl_pol,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] ack,
   output logic [W-1:0] pend
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise_ev, fall_ev, nxt, bit_q;

      always_comb begin
         rise_ev = smp[i] & ~prev_q[i];
         fall_ev = ~smp[i] & prev_q[i];
         if (lvl_mode[i]) nxt = (smp[i] == lvl_pol[i]);
         else             nxt = (rise_en[i] & rise_ev) | (fall_en[i] & fall_ev)
                                | (bit_q & ~ack[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= nxt;
      end

      assign pend[i] = bit_q;
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int W  = 16,
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [W-1:0]     din,
   input  logic [W-1:0]     pend,
   output logic [W-1:0]     dir,
   output logic [W-1:0]     lvl_mode,
   output logic [W-1:0]     lvl_pol,
   output logic [W-1:0]     rise_en,
   output logic [W-1:0]     fall_en,
   output logic [W-1:0]     dout,
   output logic [W-1:0]     mask,
   output logic [W-1:0]     en,
   output logic [W-1:0]     ack,
   output logic [W-1:0]     status
);
   logic [W-1:0] wbits;
   assign wbits = wdata[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir      <= '0;
         lvl_mode <= '0;
         lvl_pol  <= '0;
         rise_en  <= '0;
         fall_en  <= '0;
         dout     <= '0;
         mask     <= '1;
         en       <= '0;
      end else if (we) begin
         case (addr)
            IDX_DIR:  dir      <= wbits;
            IDX_TRIG: lvl_mode <= wbits;
            IDX_POL:  lvl_pol  <= wbits;
            IDX_RISE: rise_en  <= wbits;
            IDX_FALL: fall_en  <= wbits;
            IDX_SET:  dout     <= dout | wbits;
            IDX_CLR:  dout     <= dout & ~wbits;
            IDX_MASK: mask     <= wbits;
            IDX_EN:   en       <= wbits;
            default:  ;
         endcase
      end
   end

   assign ack    = (we && addr == IDX_ACK) ? wbits : '0;
   assign status = pend & ~mask & en;

   always_comb begin
      case (addr)
         IDX_DIR:  rdata = DW'(dir);
         IDX_TRIG: rdata = DW'(lvl_mode);
         IDX_POL:  rdata = DW'(lvl_pol);
         IDX_RISE: rdata = DW'(rise_en);
         IDX_FALL: rdata = DW'(fall_en);
         IDX_DIN:  rdata = DW'(din);
         IDX_DOUT: rdata = DW'(dout);
         IDX_MASK: rdata = DW'(mask);
         IDX_EN:   rdata = DW'(en);
         IDX_STAT: rdata = DW'(status);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [3:0]       bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);
   if (NPINS > DW || NPINS < 1) begin : g_chk
      $error("NPINS must be between 1 and DW");
   end

   logic [NPINS-1:0] din_w, pend_w, trig_w, pol_w, rise_w, fall_w;
   logic [NPINS-1:0] mask_w, en_w, ack_w, stat_w;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_w));

   gpio_regfile #(.W(NPINS), .DW(DW)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .din(din_w), .pend(pend_w),
      .dir(pin_oe), .lvl_mode(trig_w), .lvl_pol(pol_w), .rise_en(rise_w),
      .fall_en(fall_w), .dout(pin_out), .mask(mask_w), .en(en_w),
      .ack(ack_w), .status(stat_w));

   gpio_irq_detect #(.W(NPINS)) det_i (
      .clk(clk), .rst_n(rst_n), .smp(din_w), .lvl_mode(trig_w),
      .lvl_pol(pol_w), .rise_en(rise_w), .fall_en(fall_w), .ack(ack_w),
      .pend(pend_w));

   assign irq = |stat_w;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
   import gpio_irq_pkg::*;
#(
   parameter int W  = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic [3:0]    bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [W-1:0]  pin_out,
   input logic          irq,
   input logic [W-1:0]  pend,
   input logic [W-1:0]  trig,
   input logic [W-1:0]  mask,
   input logic [W-1:0]  en
);
   // R3
   set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == IDX_SET) |=>
      ((pin_out & $past(bus_wdata[W-1:0])) == $past(bus_wdata[W-1:0])));

   // R3
   clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == IDX_CLR) |=>
      ((pin_out & $past(bus_wdata[W-1:0])) == '0));

   // R7
   edge_pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == IDX_ACK) |=>
      ((pend & $past(pend & ~trig)) == $past(pend & ~trig)));

   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.W(NPINS), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .pin_out(pin_out), .irq(irq), .pend(pend_w),
   .trig(trig_w), .mask(mask_w), .en(en_w));

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_we = 1'b0;
   logic [3:0]  b_addr = 4'd0;
   logic [15:0] b_wdata = 16'h0;
   logic [15:0] pin_in = 16'h0;
   logic [15:0] bus_rdata, pin_out, pin_oe;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(b_we), .bus_addr(b_addr),
      .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   // Behavioural reference state
   logic [15:0] m_s1, m_s2, m_prev, m_pend, m_np;
   logic [15:0] m_dir, m_trig, m_pol, m_rise, m_fall, m_out, m_mask, m_en;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
         m_dir = 0; m_trig = 0; m_pol = 0; m_rise = 0; m_fall = 0;
         m_out = 0; m_mask = 16'hFFFF; m_en = 0;
      end else begin
         for (int i = 0; i < 16; i++) begin
            if (m_trig[i]) m_np[i] = (m_s2[i] == m_pol[i]);
            else begin
               bit up, dn, cl;
               up = m_s2[i] && !m_prev[i];
               dn = !m_s2[i] && m_prev[i];
               cl = b_we && b_addr == 4'd13 && b_wdata[i];
               m_np[i] = (m_rise[i] && up) || (m_fall[i] && dn) || (m_pend[i] && !cl);
            end
         end
         m_pend = m_np;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
         if (b_we) begin
            case (b_addr)
               4'd0:  m_dir  = b_wdata;
               4'd1:  m_trig = b_wdata;
               4'd2:  m_pol  = b_wdata;
               4'd3:  m_rise = b_wdata;
               4'd4:  m_fall = b_wdata;
               4'd6:  m_out  = m_out | b_wdata;
               4'd7:  m_out  = m_out & ~b_wdata;
               4'd10: m_mask = b_wdata;
               4'd11: m_en   = b_wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [15:0] mread(input logic [3:0] a);
      case (a)
         4'd0:  return m_dir;
         4'd1:  return m_trig;
         4'd2:  return m_pol;
         4'd3:  return m_rise;
         4'd4:  return m_fall;
         4'd5:  return m_s2;
         4'd8:  return m_out;
         4'd10: return m_mask;
         4'd11: return m_en;
         4'd12: return m_pend & ~m_mask & m_en;
         default: return 16'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison of the output ports against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         check("R2 pin_oe", pin_oe, m_dir);
         check("R3 pin_out", pin_out, m_out);
         check("R8 irq", {15'h0, irq}, {15'h0, |(m_pend & ~m_mask & m_en)});
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk); b_we = 1'b1; b_addr = a; b_wdata = d;
      @(negedge clk); b_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      @(negedge clk); b_addr = a; #0.5;
      check(tag, bus_rdata, mread(a));
   endtask

   task automatic pins(input logic [15:0] v);
      @(negedge clk); pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1: reset values
      @(negedge clk); b_addr = 4'd10; #0.5; check("R1 mask reset", bus_rdata, 16'hFFFF);
      @(negedge clk); b_addr = 4'd11; #0.5; check("R1 enable reset", bus_rdata, 16'h0000);
      for (int a = 0; a < 9; a++) rd(4'(a), "R1 register reset");
      check("R1 irq reset", {15'h0, irq}, 16'h0);

      // R2: direction
      wr(4'd0, 16'h00F0);
      rd(4'd0, "R2 direction readback");
      check("R2 oe value", pin_oe, 16'h00F0);

      // R3: set and clear strobes
      wr(4'd6, 16'h0005);
      wr(4'd6, 16'h0000);
      rd(4'd8, "R3 after set");
      wr(4'd7, 16'h0001);
      @(negedge clk); b_addr = 4'd8; #0.5; check("R3 after clear", bus_rdata, 16'h0004);
      wr(4'd7, 16'h0000);
      check("R3 zero clear keeps", pin_out, 16'h0004);

      // R4: input synchroniser latency
      @(negedge clk); pin_in = 16'hA5A5; b_addr = 4'd5;
      @(negedge clk); #0.5; check("R4 one edge old", bus_rdata, 16'h0000);
      @(negedge clk); #0.5; check("R4 two edges new", bus_rdata, 16'hA5A5);
      pins(16'h0000); idle(3);
      rd(4'd5, "R4 returns low");

      // R5: edge enables (bit0 rise, bit1 fall, bit2 both, bit3 rise)
      wr(4'd3, 16'h000D);
      wr(4'd4, 16'h0006);
      wr(4'd10, 16'h0000);
      wr(4'd11, 16'hFFFF);
      pins(16'h0007); idle(3);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R5 rising", bus_rdata, 16'h0005);
      pins(16'h0000); idle(3);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R5 falling", bus_rdata, 16'h0007);

      // R7: clear by writing ones, zeros keep
      wr(4'd13, 16'h0001);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R7 partial clear", bus_rdata, 16'h0006);
      wr(4'd13, 16'h0006);
      rd(4'd12, "R7 full clear");

      // R7: edge and clear on the same edge, edge wins
      pin_in = 16'h0008;
      @(negedge clk);
      @(negedge clk);
      b_we = 1'b1; b_addr = 4'd13; b_wdata = 16'h0008;
      @(negedge clk); b_we = 1'b0; b_addr = 4'd12; #0.5;
      check("R7 edge beats clear", bus_rdata, 16'h0008);
      rd(4'd12, "R7 model agrees");
      wr(4'd13, 16'h0008);
      pins(16'h0000); idle(3);
      rd(4'd12, "R7 cleared");

      // R6: level mode, bit8 high-active, bit9 low-active
      wr(4'd1, 16'h0300);
      wr(4'd2, 16'h0100);
      pins(16'h0100); idle(3);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R6 both levels active", bus_rdata, 16'h0300);
      wr(4'd13, 16'h0300);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R6 clear ignored", bus_rdata, 16'h0300);
      pins(16'h0200); idle(3);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R6 levels inactive", bus_rdata, 16'h0000);
      wr(4'd1, 16'h0000);

      // R8: mask and enable gating keep pending state
      pins(16'h0201); idle(3);
      wr(4'd10, 16'h0001);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R8 masked hidden", bus_rdata, 16'h0000);
      check("R8 irq low masked", {15'h0, irq}, 16'h0);
      wr(4'd11, 16'h0000);
      wr(4'd10, 16'h0000);
      rd(4'd12, "R8 disabled hidden");
      wr(4'd11, 16'h0001);
      @(negedge clk); b_addr = 4'd12; #0.5; check("R8 pending kept", bus_rdata, 16'h0001);
      check("R8 irq high", {15'h0, irq}, 16'h1);
      wr(4'd13, 16'h0001);

      // R9: write-only and unmapped words read zero
      @(negedge clk); b_addr = 4'd6;  #0.5; check("R9 set word", bus_rdata, 16'h0000);
      @(negedge clk); b_addr = 4'd7;  #0.5; check("R9 clear word", bus_rdata, 16'h0000);
      @(negedge clk); b_addr = 4'd9;  #0.5; check("R9 word 9", bus_rdata, 16'h0000);
      @(negedge clk); b_addr = 4'd13; #0.5; check("R9 ack word", bus_rdata, 16'h0000);
      @(negedge clk); b_addr = 4'd14; #0.5; check("R9 word 14", bus_rdata, 16'h0000);
      @(negedge clk); b_addr = 4'd15; #0.5; check("R9 word 15", bus_rdata, 16'h0000);

      idle(2);
      summary();
   end
endmodule